// File: doc/BRIEF.md
# Dual-Width Integer ALU with Byte Swap

This block performs the integer arithmetic group of a 64-bit register machine: add, subtract, multiply, unsigned and signed divide and modulo, bitwise or, and, xor, left shift, logical and arithmetic right shift, negate, plain and sign-extending move, and byte-order conversion. The destination operand always comes from a 64-bit input. The second operand is either a register value or a 32-bit immediate. A width input selects whether the operation behaves as a 32-bit or a 64-bit operation.

An operation begins when `start` is high in a cycle where `busy` is low. Every operation except divide and modulo finishes in one cycle. Divide and modulo run on a radix-2 restoring divider that produces one quotient bit per cycle. While it runs, `busy` is high and further starts are ignored. Completion is shown by a single-cycle `done` pulse, and `result` holds its value until the next completion. The 16-bit `offset` input chooses between variants of the same opcode: signed divide and modulo, and the source width of a sign-extending move.

Top module: `dwalu_top`

## Requirements
- R1: For every opcode other than 3 and 9, a start accepted at a clock edge makes `done` high for the following cycle, with `result` valid in that cycle. `result` changes only at an edge that also raises `done`.
- R2: For opcodes 3 and 9, `busy` is high from the edge that accepts the start until the edge that raises `done`. `busy` and `done` are never high together. A start raised while `busy` is high has no effect on the result.
- R3: Opcodes are 0 add, 1 subtract, 2 multiply, 4 or, 5 and, 8 negate (dst only), 10 xor, and 11 with offset 0 move. All of them wrap. When `wide` is 0, the operation uses the low 32 bits and the upper 32 bits of the result are zero.
- R4: When `use_reg` is 1, the second operand is `src_val`. When it is 0, the second operand is `imm` sign-extended to 64 bits and `src_val` is ignored.
- R5: Opcode 6 shifts left, 7 shifts right logically, and 12 shifts right arithmetically. The shift amount is the second operand masked with 63 when `wide` is 1 and with 31 when `wide` is 0. In 32-bit mode the arithmetic shift takes its sign from bit 31.
- R6: Opcode 3 is divide and opcode 9 is modulo. With offset 1 they are signed, otherwise unsigned. Signed modulo truncates, so the remainder takes the sign of the dividend. The most negative value divided by -1 gives the most negative value, and its modulo gives 0.
- R7: A divisor of zero makes divide return 0. Modulo by zero returns the destination unchanged when `wide` is 1, and the destination with its upper 32 bits cleared when `wide` is 0.
- R8: Opcode 11 with offset 8 or 16 sign-extends the low 8 or 16 bits of the second operand. With offset 32 and `wide` 1, it sign-extends the low 32 bits. In 32-bit mode the upper half is then cleared, and offset 32 acts as a plain move.
- R9: Opcode 13 with `wide` 1 reverses the bytes of the low 16, 32 or 64 bits of the destination, with the width taken from `imm`, and zero-extends the result.
- R10: Opcode 13 with `wide` 0 converts to little-endian when `use_reg` is 0 and to big-endian when `use_reg` is 1, relative to a little-endian host (`HOST_BE` = 0). A conversion to the host order only zero-extends the low 16, 32 or 64 bits. A width of 64 yields a full 64-bit result in either mode.
- R11: After reset, `busy` and `done` are 0 and `result` is 0.
- R12: Opcode 13 with an `imm` other than 16, 32 or 64, and opcodes 14 and 15, return the destination unchanged in one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an operation; accepted when `busy` is low |
| opcode | input | 4 | Operation code |
| offset | input | 16 | Variant selector (signed div/mod, sign-extend width) |
| wide | input | 1 | 1 = 64-bit behaviour, 0 = 32-bit behaviour |
| use_reg | input | 1 | Second operand from `src_val` (1) or `imm` (0); endian select for opcode 13 |
| dst_val | input | 64 | Destination operand |
| src_val | input | 64 | Register source operand |
| imm | input | 32 | Immediate operand; swap width for opcode 13 |
| busy | output | 1 | Divider occupied |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Registered result |

## Verification
The assertions assume that the operand and control inputs stay steady only during the cycle in which `start` is accepted. They also assume that a start raised during `busy` is dropped, not queued. The bench therefore changes inputs on falling edges and holds `start` for exactly one cycle per operation. It raises one deliberate start during a division to check that the start is ignored. Its operand sweep covers the values that matter at width boundaries: zero, one, minus one, the 32-bit and 64-bit sign-bit values, shift amounts above the mask, and the most-negative-by-minus-one pair. It runs every opcode in both widths and both source modes against a model computed in the bench.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_DIV  = 4'h3,
    OP_OR   = 4'h4,
    OP_AND  = 4'h5,
    OP_LSH  = 4'h6,
    OP_RSH  = 4'h7,
    OP_NEG  = 4'h8,
    OP_MOD  = 4'h9,
    OP_XOR  = 4'hA,
    OP_MOV  = 4'hB,
    OP_ARSH = 4'hC,
    OP_END  = 4'hD
  } alu_op_e;

  localparam logic [15:0] OFF_SIGNED = 16'd1;
  localparam logic [15:0] OFF_SX8    = 16'd8;
  localparam logic [15:0] OFF_SX16   = 16'd16;
  localparam logic [15:0] OFF_SX32   = 16'd32;
endpackage

// File: rtl/alu_endian.sv
module alu_endian #(
  parameter int DW      = 64,
  parameter bit HOST_BE = 1'b0
) (
  input  logic [DW-1:0]   val,
  input  logic [DW/2-1:0] width_sel,
  input  logic            force_swap,
  input  logic            to_be,
  output logic [DW-1:0]   res
);
  localparam int HW = DW / 2;
  localparam int NW = $clog2(DW / 16) + 1;

  logic [DW-1:0] rev_w [NW];
  logic [DW-1:0] cut_w [NW];

  for (genvar k = 0; k < NW; k++) begin : g_w
    localparam int WK = 16 << k;
    localparam int NB = WK / 8;
    logic [DW-1:0] rv;
    for (genvar i = 0; i < NB; i++) begin : g_b
      assign rv[8*i +: 8] = val[WK-8-8*i +: 8];
    end
    if (WK < DW) begin : g_pad
      assign rv[DW-1:WK] = '0;
      assign cut_w[k]    = {{(DW-WK){1'b0}}, val[WK-1:0]};
    end else begin : g_full
      assign cut_w[k] = val;
    end
    assign rev_w[k] = rv;
  end

  logic do_swap;
  always_comb begin
    do_swap = force_swap || (to_be != HOST_BE);
    res     = val;
    for (int k = 0; k < NW; k++) begin
      if (width_sel == HW'(16 << k)) res = do_swap ? rev_w[k] : cut_w[k];
    end
  end
endmodule

// File: rtl/alu_onecyc.sv
module alu_onecyc import alu_pkg::*; #(
  parameter int DW      = 64,
  parameter bit HOST_BE = 1'b0
) (
  input  logic [3:0]      opcode,
  input  logic [15:0]     offset,
  input  logic            wide,
  input  logic            use_reg,
  input  logic [DW-1:0]   dst_val,
  input  logic [DW-1:0]   src_op,
  input  logic [DW/2-1:0] imm,
  output logic [DW-1:0]   res
);
  localparam int HW  = DW / 2;
  localparam int SHW = $clog2(DW);

  logic [DW-1:0]  a_z, b_z, a_s, raw, mov_v, swapped;
  logic [SHW-1:0] amt;
  logic           keep_full;

  alu_endian #(.DW(DW), .HOST_BE(HOST_BE)) u_endian (
    .val        (dst_val),
    .width_sel  (imm),
    .force_swap (wide),
    .to_be      (use_reg),
    .res        (swapped)
  );

  always_comb begin
    a_z = wide ? dst_val : {{HW{1'b0}}, dst_val[HW-1:0]};
    b_z = wide ? src_op  : {{HW{1'b0}}, src_op[HW-1:0]};
    a_s = wide ? dst_val : {{HW{dst_val[HW-1]}}, dst_val[HW-1:0]};
    amt = wide ? src_op[SHW-1:0] : {1'b0, src_op[SHW-2:0]};

    mov_v = src_op;
    if (offset == OFF_SX8)
      mov_v = {{(DW-8){src_op[7]}}, src_op[7:0]};
    else if (offset == OFF_SX16)
      mov_v = {{(DW-16){src_op[15]}}, src_op[15:0]};
    else if (offset == OFF_SX32 && wide)
      mov_v = {{HW{src_op[HW-1]}}, src_op[HW-1:0]};

    keep_full = 1'b0;
    case (opcode)
      OP_ADD:  raw = a_z + b_z;
      OP_SUB:  raw = a_z - b_z;
      OP_MUL:  raw = a_z * b_z;
      OP_OR:   raw = a_z | b_z;
      OP_AND:  raw = a_z & b_z;
      OP_XOR:  raw = a_z ^ b_z;
      OP_LSH:  raw = a_z << amt;
      OP_RSH:  raw = a_z >> amt;
      OP_ARSH: raw = DW'($signed(a_s) >>> amt);
      OP_NEG:  raw = '0 - a_z;
      OP_MOV:  raw = mov_v;
      OP_END: begin
        raw       = swapped;
        keep_full = 1'b1;
      end
      default: begin
        raw       = dst_val;
        keep_full = 1'b1;
      end
    endcase

    res = (wide || keep_full) ? raw : {{HW{1'b0}}, raw[HW-1:0]};
  end
endmodule

// File: rtl/alu_divider.sv
module alu_divider #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         fin,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;
  logic          run;
  logic [W-1:0]  dsr;
  logic [W:0]    trial;
  logic [W-1:0]  shifted;

  always_comb begin
    shifted = {rem[W-2:0], quo[W-1]};
    trial   = {rem, quo[W-1]} - {1'b0, dsr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      fin <= 1'b0;
      cnt <= '0;
      quo <= '0;
      rem <= '0;
      dsr <= '0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        run <= 1'b1;
        cnt <= CW'(W);
        quo <= num;
        rem <= '0;
        dsr <= den;
      end else if (run) begin
        if (!trial[W]) begin
          rem <= trial[W-1:0];
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= shifted;
          quo <= {quo[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dwalu_top.sv
module dwalu_top import alu_pkg::*; #(
  parameter int DW      = 64,
  parameter bit HOST_BE = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [3:0]      opcode,
  input  logic [15:0]     offset,
  input  logic            wide,
  input  logic            use_reg,
  input  logic [DW-1:0]   dst_val,
  input  logic [DW-1:0]   src_val,
  input  logic [DW/2-1:0] imm,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   result
);
  localparam int HW = DW / 2;

  logic          accept, is_dm, sgn, a_neg, b_neg;
  logic [DW-1:0] src_op, one_res, a_ext, b_ext, num, den;
  logic          div_fin;
  logic [DW-1:0] quo, rem, q_fix, r_fix, dm_res;

  logic          p_mod, p_neg_q, p_neg_r, p_bz, p_wide;
  logic [DW-1:0] p_dst;

  assign accept = start && !busy;
  assign is_dm  = (opcode == OP_DIV) || (opcode == OP_MOD);
  assign src_op = use_reg ? src_val : {{(DW-HW){imm[HW-1]}}, imm};

  alu_onecyc #(.DW(DW), .HOST_BE(HOST_BE)) u_onecyc (
    .opcode  (opcode),
    .offset  (offset),
    .wide    (wide),
    .use_reg (use_reg),
    .dst_val (dst_val),
    .src_op  (src_op),
    .imm     (imm),
    .res     (one_res)
  );

  always_comb begin
    sgn   = (offset == OFF_SIGNED);
    a_ext = wide ? dst_val
          : (sgn ? {{HW{dst_val[HW-1]}}, dst_val[HW-1:0]} : {{HW{1'b0}}, dst_val[HW-1:0]});
    b_ext = wide ? src_op
          : (sgn ? {{HW{src_op[HW-1]}}, src_op[HW-1:0]} : {{HW{1'b0}}, src_op[HW-1:0]});
    a_neg = sgn && a_ext[DW-1];
    b_neg = sgn && b_ext[DW-1];
    num   = a_neg ? ('0 - a_ext) : a_ext;
    den   = b_neg ? ('0 - b_ext) : b_ext;
  end

  alu_divider #(.W(DW)) u_div (
    .clk  (clk),
    .rst  (rst),
    .load (accept && is_dm),
    .num  (num),
    .den  (den),
    .fin  (div_fin),
    .quo  (quo),
    .rem  (rem)
  );

  always_comb begin
    q_fix  = p_neg_q ? ('0 - quo) : quo;
    r_fix  = p_neg_r ? ('0 - rem) : rem;
    dm_res = p_bz ? (p_mod ? p_dst : '0) : (p_mod ? r_fix : q_fix);
    if (!p_wide) dm_res = {{HW{1'b0}}, dm_res[HW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      result  <= '0;
      p_mod   <= 1'b0;
      p_neg_q <= 1'b0;
      p_neg_r <= 1'b0;
      p_bz    <= 1'b0;
      p_wide  <= 1'b0;
      p_dst   <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (is_dm) begin
          busy    <= 1'b1;
          p_mod   <= (opcode == OP_MOD);
          p_neg_q <= a_neg ^ b_neg;
          p_neg_r <= a_neg;
          p_bz    <= (b_ext == '0);
          p_wide  <= wide;
          p_dst   <= dst_val;
        end else begin
          result <= one_res;
          done   <= 1'b1;
        end
      end else if (div_fin) begin
        result <= dm_res;
        done   <= 1'b1;
        busy   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dwalu_chk.sv
module dwalu_chk import alu_pkg::*; #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [3:0]    opcode,
  input logic          wide,
  input logic          use_reg,
  input logic [DW-1:0] src_val,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] result
);
  localparam int HW = DW / 2;

  logic acc, acc_dm;
  logic r_wide, r_isend, r_divz;

  assign acc    = start && !busy;
  assign acc_dm = acc && (opcode == OP_DIV || opcode == OP_MOD);

  always_ff @(posedge clk) begin
    if (rst) begin
      r_wide  <= 1'b1;
      r_isend <= 1'b0;
      r_divz  <= 1'b0;
    end else if (acc) begin
      r_wide  <= wide;
      r_isend <= (opcode == OP_END) || (opcode > OP_END);
      r_divz  <= (opcode == OP_DIV) && use_reg &&
                 (wide ? (src_val == '0) : (src_val[HW-1:0] == '0));
    end
  end

  AST_FAST_OP_DONE: assert property (@(posedge clk) disable iff (rst)
    acc && !acc_dm |=> done && !busy); // R1

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result)); // R1

  AST_DIV_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
    acc_dm |=> busy && !done); // R2

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R2

  AST_UPPER_CLEAR_32: assert property (@(posedge clk) disable iff (rst)
    done && !r_wide && !r_isend |-> result[DW-1:HW] == '0); // R3

  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (rst)
    done && r_divz |-> result == '0); // R7
endmodule

bind dwalu_top dwalu_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .opcode  (opcode),
  .wide    (wide),
  .use_reg (use_reg),
  .src_val (src_val),
  .busy    (busy),
  .done    (done),
  .result  (result)
);

// File: tb/tb_dwalu_top.sv
module tb_dwalu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  opcode = '0;
  logic [15:0] offset = '0;
  logic        wide = 1'b0;
  logic        use_reg = 1'b0;
  logic [63:0] dst_val = '0;
  logic [63:0] src_val = '0;
  logic [31:0] imm = '0;
  logic        busy, done;
  logic [63:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dwalu_top dut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .offset(offset),
    .wide(wide), .use_reg(use_reg), .dst_val(dst_val), .src_val(src_val),
    .imm(imm), .busy(busy), .done(done), .result(result)
  );

  logic [63:0] vals [10] = '{
    64'h0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7F, 64'h0000_0000_8000_0000,
    64'h8000_0000_0000_0000, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFF9,
    64'h25, 64'h0000_0001_0000_0003
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  function automatic logic [63:0] zx(input logic [31:0] v);
    return {32'b0, v};
  endfunction

  function automatic logic [63:0] model(input int op, input int off, input bit w, input bit ur,
                                        input logic [63:0] d, input logic [63:0] s,
                                        input logic [31:0] im);
    logic [63:0] sv, r;
    logic [31:0] d32, s32;
    logic signed [63:0] sd, ss;
    logic signed [31:0] sd3, ss3;
    sv  = ur ? s : {{32{im[31]}}, im};
    d32 = d[31:0];
    s32 = sv[31:0];
    sd  = d;  ss  = sv;
    sd3 = d32; ss3 = s32;
    case (op)
      0:  r = w ? d + sv : zx(d32 + s32);
      1:  r = w ? d - sv : zx(d32 - s32);
      2:  r = w ? d * sv : zx(d32 * s32);
      4:  r = w ? d | sv : zx(d32 | s32);
      5:  r = w ? d & sv : zx(d32 & s32);
      10: r = w ? d ^ sv : zx(d32 ^ s32);
      8:  r = w ? -d : zx(-d32);
      6:  r = w ? d << sv[5:0] : zx(d32 << s32[4:0]);
      7:  r = w ? d >> sv[5:0] : zx(d32 >> s32[4:0]);
      12: r = w ? 64'(sd >>> sv[5:0]) : zx(32'(sd3 >>> s32[4:0]));
      3: begin
        if (off == 1) begin
          if (w) r = (sv == 0) ? 64'h0 : (d == 64'h8000_0000_0000_0000 && sv == '1) ? d : 64'(sd / ss);
          else   r = (s32 == 0) ? 64'h0 : (d32 == 32'h8000_0000 && s32 == '1) ? zx(d32) : zx(32'(sd3 / ss3));
        end else begin
          if (w) r = (sv == 0) ? 64'h0 : d / sv;
          else   r = (s32 == 0) ? 64'h0 : zx(d32 / s32);
        end
      end
      9: begin
        if (off == 1) begin
          if (w) r = (sv == 0) ? d : (sv == '1) ? 64'h0 : 64'(sd % ss);
          else   r = (s32 == 0) ? zx(d32) : (s32 == '1) ? 64'h0 : zx(32'(sd3 % ss3));
        end else begin
          if (w) r = (sv == 0) ? d : d % sv;
          else   r = (s32 == 0) ? zx(d32) : zx(d32 % s32);
        end
      end
      11: begin
        if (w) begin
          if (off == 8)       r = {{56{sv[7]}}, sv[7:0]};
          else if (off == 16) r = {{48{sv[15]}}, sv[15:0]};
          else if (off == 32) r = {{32{sv[31]}}, sv[31:0]};
          else                r = sv;
        end else begin
          if (off == 8)       r = zx({{24{s32[7]}}, s32[7:0]});
          else if (off == 16) r = zx({{16{s32[15]}}, s32[15:0]});
          else                r = zx(s32);
        end
      end
      13: begin
        bit sw;
        sw = w || ur;
        case (im)
          32'd16:  r = sw ? {48'b0, d[7:0], d[15:8]} : {48'b0, d[15:0]};
          32'd32:  r = sw ? {32'b0, d[7:0], d[15:8], d[23:16], d[31:24]} : zx(d32);
          32'd64:  r = sw ? {<<8{d}} : d;
          default: r = d;
        endcase
      end
      default: r = d;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input int op, input int off, input bit ur);
    string t;
    case (op)
      0, 1, 2, 4, 5, 8, 10: t = "R3";
      6, 7, 12:             t = "R5";
      3, 9:                 t = "R6 R7";
      11:                   t = (off == 0) ? "R3" : "R8";
      13:                   t = "R9 R10 R12";
      default:              t = "R12";
    endcase
    if (!ur && op != 13) t = {t, " R4"};
    return t;
  endfunction

  task automatic do_op(input int op, input int off, input bit w, input bit ur,
                       input logic [63:0] d, input logic [63:0] s, input logic [31:0] im);
    logic [63:0] exp;
    string       t, what;
    bit          dm;
    int          waitc;
    dm  = (op == 3) || (op == 9);
    exp = model(op, off, w, ur, d, s, im);
    t   = tag_of(op, off, ur);
    what = $sformatf("op=%0d off=%0d w=%0b ur=%0b d=%h s=%h imm=%h", op, off, w, ur, d, s, im);
    @(negedge clk);
    opcode = 4'(op); offset = 16'(off); wide = w; use_reg = ur;
    dst_val = d; imm = im;
    src_val = ur ? s : ~s;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (dm) chk(busy && !done, "R2", {"busy after start ", what}, {62'b0, busy, done}, 64'h2);
    else    chk(done && !busy, "R1", {"one-cycle done ", what}, {62'b0, busy, done}, 64'h1);
    waitc = 0;
    while (!done && waitc < 200) begin
      @(negedge clk);
      waitc++;
    end
    chk(result === exp, t, what, result, exp);
  endtask

  initial begin
    int offs_mov [5] = '{0, 8, 16, 32, 3};
    int widths [5]   = '{16, 32, 64, 8, 0};
    logic [63:0] held;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && result == 64'h0, "R11", "reset state",
        {busy, done, result[61:0]}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && result == 64'h0, "R11", "after reset release",
        result, 64'h0);

    for (int op = 0; op < 16; op++) begin
      if (op == 13) continue;
      for (int w = 0; w < 2; w++)
        for (int ur = 0; ur < 2; ur++) begin
          int noff;
          noff = (op == 11) ? 5 : (op == 3 || op == 9) ? 2 : 1;
          for (int oi = 0; oi < noff; oi++) begin
            int off;
            off = (op == 11) ? offs_mov[oi] : oi;
            for (int ai = 0; ai < 10; ai++)
              for (int bi = 0; bi < 10; bi++)
                do_op(op, off, w[0], ur[0], vals[ai], vals[bi], vals[bi][31:0]);
          end
        end
    end

    // R9 R10 R12: byte swap over widths, classes and endian selects
    for (int w = 0; w < 2; w++)
      for (int ur = 0; ur < 2; ur++)
        for (int wi = 0; wi < 5; wi++)
          for (int ai = 0; ai < 10; ai++)
            do_op(13, 0, w[0], ur[0], vals[ai], 64'hDEAD, 32'(widths[wi]));

    // R2: start during busy is ignored
    @(negedge clk);
    opcode = 4'd3; offset = 16'd0; wide = 1'b1; use_reg = 1'b1;
    dst_val = 64'd100; src_val = 64'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    opcode = 4'd0; dst_val = 64'd5; src_val = 64'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && done == 1'b0, "R2", "start while busy ignored", {62'b0, busy, done}, 64'h2);
    for (int k = 0; k < 200 && !done; k++) @(negedge clk);
    chk(result == 64'd14, "R2", "div result after ignored start", result, 64'd14);
    held = result;
    @(negedge clk);
    chk(done == 1'b0 && result == held, "R1 R2", "no extra completion", result, held);
    repeat (3) @(negedge clk);
    chk(result == held && !busy, "R1", "result holds", result, held);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1 got=%0d exp=%0d", cycles, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule